// File: doc/BRIEF.md
# MMIO Register Window Bridge

This block answers a 4 KiB memory-mapped window and turns each upstream access into the cycles a display controller understands. Two small areas of the window are live. A 32-byte area reaches the legacy byte-wide registers through a byte port. An area of eleven 16-bit slots reaches the extended registers through an index/data port. Every other offset in the window reads as zero and discards writes.

The upstream master pulses `req_valid` for one cycle while the block is idle. It then waits for the one-cycle `rsp_ready` pulse, which carries read data. The block splits an access that is wider than its target into ordered downstream cycles and runs them one at a time. Each downstream cycle holds its valid until the matching ack. Multi-byte data is little endian throughout: `req_wdata[7:0]` and `rsp_rdata[7:0]` belong to the lowest address.

Top module: `mmio_reg_bridge`

## Requirements
- R1: A request seen while `en` is low is dropped: no downstream cycle and no `rsp_ready` follow. `en` is sampled only when a request is accepted, so an access already accepted runs to completion even if `en` falls.
- R2: Byte offsets 0x400 to 0x41F drive `lg_port` with offset minus 0x400 (0 to 31, which stands for legacy ports 0x3C0 to 0x3DF).
- R3: A 2-byte write to the legacy area makes two byte cycles. The first writes `req_wdata[7:0]` to the addressed port. The second writes `req_wdata[15:8]` to the next port.
- R4: A 2-byte read from the legacy area returns the addressed port in bits 7:0 and the following port in bits 15:8. Upper bits are zero.
- R5: An access whose address is in 0x500 to 0x515 uses the extended port. For each 16-bit unit, the block first makes an index cycle (`ex_sel_index`=1, `ex_write`=1, `ex_wdata` = (offset minus 0x500) shifted right by one, range 0 to 10). It then makes the data cycle (`ex_sel_index`=0).
- R6: A 2-byte extended access moves `req_wdata[15:0]` or returns `rsp_rdata[15:0]`. Address bit 0 does not change the index.
- R7: A 1-byte extended access is widened to one 16-bit cycle. A read returns the byte lane chosen by address bit 0 (0 = bits 7:0) in `rsp_rdata[7:0]`. A write puts `req_wdata[7:0]` in that lane and zero in the other.
- R8: `req_size` gives the byte count 1 or 2. Any other value acts as 4. A 4-byte access runs as two 16-bit halves, the lower address first, and its read returns {high half, low half}. In the legacy area this is four byte cycles in ascending address order. In the extended area it is two index/data pairs on consecutive indices.
- R9: Any byte or 16-bit unit of an access that falls outside both areas makes no downstream cycle and reads as zero. The access still completes with `rsp_ready`.
- R10: After reset all valids and `rsp_ready` are low. At most one downstream cycle is in flight. `rsp_ready` is a single-cycle pulse that comes only after the last downstream cycle of the access has been acked. Write responses return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Window enable, sampled when a request is accepted |
| req_valid | input | 1 | One-cycle request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Byte count: 1, 2, anything else means 4 |
| req_addr | input | 12 | Byte offset in the window |
| req_wdata | input | 32 | Write data, little endian |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready |
| lg_valid | output | 1 | Legacy byte cycle request |
| lg_write | output | 1 | Legacy cycle direction |
| lg_port | output | 5 | Legacy register number (0 = port 0x3C0) |
| lg_wdata | output | 8 | Legacy write byte |
| lg_rdata | input | 8 | Legacy read byte, valid with lg_ack |
| lg_ack | input | 1 | Legacy cycle done |
| ex_valid | output | 1 | Extended cycle request |
| ex_sel_index | output | 1 | 1 = index cycle, 0 = data cycle |
| ex_write | output | 1 | Extended cycle direction |
| ex_wdata | output | 16 | Index value or write data |
| ex_rdata | input | 16 | Extended read data, valid with ex_ack |
| ex_ack | input | 1 | Extended cycle done |

## Verification
The enable gate and the sequencing of an accepted access can meet in one cycle. The bench provokes this in two ways. First it strobes a request with `en` low, and expects neither a downstream cycle nor a response in the cycles that follow. Then it lowers `en` two cycles into a 4-byte legacy read, and expects the full four-byte result with exactly one response pulse. The bench models both downstream ports as register files that ack one cycle after valid. It logs every completed downstream cycle, so it judges ordering (index before data, low byte before high byte) from that log rather than from the design's internals.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_LG,
        ST_EXI,
        ST_EXD,
        ST_RESP
    } mrb_state_e;
endpackage

// File: rtl/mrb_step_decode.sv
module mrb_step_decode #(
    parameter int ADDR_W  = 12,
    parameter int CNT_W   = 3,
    parameter int LG_BASE = 'h400,
    parameter int LG_SPAN = 32,
    parameter int EX_BASE = 'h500,
    parameter int EX_REGS = 11,
    localparam int LG_PORT_W = $clog2(LG_SPAN),
    localparam int EX_IDX_W  = $clog2(EX_REGS)
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [CNT_W-1:0]     cnt,
    output logic                 lg_hit,
    output logic [LG_PORT_W-1:0] lg_port,
    output logic                 ex_hit,
    output logic [EX_IDX_W-1:0]  ex_idx
);
    localparam logic [ADDR_W-1:0] LG_LO = ADDR_W'(LG_BASE);
    localparam logic [ADDR_W-1:0] LG_HI = ADDR_W'(LG_BASE + LG_SPAN);
    localparam logic [ADDR_W-2:0] EW_LO = (ADDR_W-1)'(EX_BASE / 2);
    localparam logic [ADDR_W-2:0] EW_HI = (ADDR_W-1)'(EX_BASE / 2 + EX_REGS);

    logic [ADDR_W-1:0] byte_a;
    logic [ADDR_W-2:0] word_a;

    // byte step for legacy sequencing, 16-bit step for extended sequencing
    assign byte_a  = base + ADDR_W'(cnt);
    assign word_a  = base[ADDR_W-1:1] + (ADDR_W-1)'(cnt);
    assign lg_hit  = (byte_a >= LG_LO) && (byte_a < LG_HI);
    assign lg_port = LG_PORT_W'(byte_a - LG_LO);
    assign ex_hit  = (word_a >= EW_LO) && (word_a < EW_HI);
    assign ex_idx  = EX_IDX_W'(word_a - EW_LO);
endmodule

// File: rtl/mrb_lane.sv
module mrb_lane #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              sz1,
    input  logic              lane,
    output logic [7:0]        bsel,
    output logic [15:0]       hsel
);
    always_comb begin
        bsel = wdata[8*cnt +: 8];
        if (sz1) begin
            hsel = lane ? {wdata[7:0], 8'h00} : {8'h00, wdata[7:0]};
        end else begin
            hsel = wdata[16*cnt +: 16];
        end
    end
endmodule

// File: rtl/mmio_reg_bridge.sv
module mmio_reg_bridge #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int LG_BASE = 'h400,
    parameter int LG_SPAN = 32,
    parameter int EX_BASE = 'h500,
    parameter int EX_REGS = 11,
    localparam int LG_PORT_W = $clog2(LG_SPAN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [2:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_ready,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 lg_valid,
    output logic                 lg_write,
    output logic [LG_PORT_W-1:0] lg_port,
    output logic [7:0]           lg_wdata,
    input  logic [7:0]           lg_rdata,
    input  logic                 lg_ack,
    output logic                 ex_valid,
    output logic                 ex_sel_index,
    output logic                 ex_write,
    output logic [15:0]          ex_wdata,
    input  logic [15:0]          ex_rdata,
    input  logic                 ex_ack
);
    import mrb_pkg::*;

    localparam int BYTES    = DATA_W / 8;
    localparam int HALVES   = DATA_W / 16;
    localparam int CNT_W    = $clog2(BYTES) + 1;
    localparam int EX_IDX_W = $clog2(EX_REGS);
    localparam logic [ADDR_W-1:0] EX_LO = ADDR_W'(EX_BASE);
    localparam logic [ADDR_W-1:0] EX_HI = ADDR_W'(EX_BASE + 2 * EX_REGS);

    typedef struct packed {
        mrb_state_e              state;
        logic                    wr;
        logic                    sz1;
        logic                    ext;
        logic [ADDR_W-1:0]       addr;
        logic [CNT_W-1:0]        cnt;
        logic [CNT_W-1:0]        nsteps;
        logic [DATA_W-1:0]       wdata;
        logic [DATA_W-1:0]       rdata;
        logic [LG_PORT_W-1:0]    port;
        logic [EX_IDX_W-1:0]     idx;
        logic [7:0]              bdat;
        logic [15:0]             hdat;
    } regs_t;

    regs_t q_q, q_d;

    logic                 st_lg_hit, st_ex_hit;
    logic [LG_PORT_W-1:0] st_port;
    logic [EX_IDX_W-1:0]  st_idx;
    logic [7:0]           st_byte;
    logic [15:0]          st_half;
    logic                 rq_ext, rq_sz1, rq_sz2;

    mrb_step_decode #(
        .ADDR_W (ADDR_W),  .CNT_W  (CNT_W),
        .LG_BASE(LG_BASE), .LG_SPAN(LG_SPAN),
        .EX_BASE(EX_BASE), .EX_REGS(EX_REGS)
    ) u_dec (
        .base   (q_q.addr),
        .cnt    (q_q.cnt),
        .lg_hit (st_lg_hit),
        .lg_port(st_port),
        .ex_hit (st_ex_hit),
        .ex_idx (st_idx)
    );

    mrb_lane #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lane (
        .wdata(q_q.wdata),
        .cnt  (q_q.cnt),
        .sz1  (q_q.sz1),
        .lane (q_q.addr[0]),
        .bsel (st_byte),
        .hsel (st_half)
    );

    assign rq_ext = (req_addr >= EX_LO) && (req_addr < EX_HI);
    assign rq_sz1 = (req_size == 3'd1);
    assign rq_sz2 = (req_size == 3'd2);

    always_comb begin
        q_d = q_q;
        case (q_q.state)
            ST_IDLE: begin
                if (req_valid && en) begin
                    q_d.state = ST_ISSUE;
                    q_d.wr    = req_write;
                    q_d.sz1   = rq_sz1;
                    q_d.ext   = rq_ext;
                    q_d.addr  = req_addr;
                    q_d.wdata = req_wdata;
                    q_d.rdata = '0;
                    q_d.cnt   = '0;
                    if (rq_ext) begin
                        q_d.nsteps = (rq_sz1 || rq_sz2) ? CNT_W'(1) : CNT_W'(HALVES);
                    end else begin
                        q_d.nsteps = rq_sz1 ? CNT_W'(1) : (rq_sz2 ? CNT_W'(2) : CNT_W'(BYTES));
                    end
                end
            end
            ST_ISSUE: begin
                if (q_q.cnt == q_q.nsteps) begin
                    q_d.state = ST_RESP;
                end else if (q_q.ext) begin
                    if (st_ex_hit) begin
                        q_d.state = ST_EXI;
                        q_d.idx   = st_idx;
                        q_d.hdat  = st_half;
                    end else begin
                        q_d.cnt = q_q.cnt + 1'b1;
                    end
                end else begin
                    if (st_lg_hit) begin
                        q_d.state = ST_LG;
                        q_d.port  = st_port;
                        q_d.bdat  = st_byte;
                    end else begin
                        q_d.cnt = q_q.cnt + 1'b1;
                    end
                end
            end
            ST_LG: begin
                if (lg_ack) begin
                    if (!q_q.wr) q_d.rdata[8*q_q.cnt +: 8] = lg_rdata;
                    q_d.cnt   = q_q.cnt + 1'b1;
                    q_d.state = ST_ISSUE;
                end
            end
            ST_EXI: begin
                if (ex_ack) q_d.state = ST_EXD;
            end
            ST_EXD: begin
                if (ex_ack) begin
                    if (!q_q.wr) begin
                        if (q_q.sz1) begin
                            q_d.rdata[7:0] = q_q.addr[0] ? ex_rdata[15:8] : ex_rdata[7:0];
                        end else begin
                            q_d.rdata[16*q_q.cnt +: 16] = ex_rdata;
                        end
                    end
                    q_d.cnt   = q_q.cnt + 1'b1;
                    q_d.state = ST_ISSUE;
                end
            end
            ST_RESP: q_d.state = ST_IDLE;
            default: q_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q       <= '0;
            q_q.state <= ST_IDLE;
        end else begin
            q_q <= q_d;
        end
    end

    assign rsp_ready    = (q_q.state == ST_RESP);
    assign rsp_rdata    = q_q.rdata;
    assign lg_valid     = (q_q.state == ST_LG);
    assign lg_write     = q_q.wr;
    assign lg_port      = q_q.port;
    assign lg_wdata     = q_q.bdat;
    assign ex_valid     = (q_q.state == ST_EXI) || (q_q.state == ST_EXD);
    assign ex_sel_index = (q_q.state == ST_EXI);
    assign ex_write     = (q_q.state == ST_EXI) ? 1'b1 : q_q.wr;
    assign ex_wdata     = (q_q.state == ST_EXI) ? 16'(q_q.idx) : q_q.hdat;

    // R1: a request with the window disabled causes no activity next cycle
    assert_gate_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.state == ST_IDLE && req_valid && !en) |=> (!lg_valid && !ex_valid && !rsp_ready));

    // R5: a data cycle on the extended port starts only right after an acked index cycle
    assert_index_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ex_valid && !ex_sel_index) |-> $past(ex_valid && ex_sel_index && ex_ack));

    // R5: the index written is always one of the existing extended registers
    assert_index_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_sel_index) |-> (ex_wdata < 16'(EX_REGS)));

    // R10: single downstream cycle in flight
    assert_one_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(lg_valid && ex_valid));

    // R10: response only when both downstream ports are quiet, and only for one cycle
    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (!lg_valid && !ex_valid));
    assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    // R2: a legacy cycle keeps its port steady until acked
    assert_port_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lg_valid && !lg_ack) |=> (lg_valid && $stable(lg_port)));
endmodule

// File: tb/tb_mmio_reg_bridge.sv
module tb_mmio_reg_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_size = 3'd1;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata;
    logic        lg_valid, lg_write;
    logic [4:0]  lg_port;
    logic [7:0]  lg_wdata;
    logic [7:0]  lg_rdata = '0;
    logic        lg_ack = 1'b0;
    logic        ex_valid, ex_sel_index, ex_write;
    logic [15:0] ex_wdata;
    logic [15:0] ex_rdata = '0;
    logic        ex_ack = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_reg_bridge dut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .lg_valid(lg_valid), .lg_write(lg_write), .lg_port(lg_port),
        .lg_wdata(lg_wdata), .lg_rdata(lg_rdata), .lg_ack(lg_ack),
        .ex_valid(ex_valid), .ex_sel_index(ex_sel_index), .ex_write(ex_write),
        .ex_wdata(ex_wdata), .ex_rdata(ex_rdata), .ex_ack(ex_ack)
    );

    // downstream models: register files acking one cycle after valid
    logic [7:0]  lg_mem [32];
    logic [15:0] ex_mem [11];
    logic [3:0]  ex_ireg = '0;
    logic [4:0]  lg_log_port [16];
    logic [7:0]  lg_log_dat [16];
    logic        ex_log_sel [16];
    logic [15:0] ex_log_dat [16];
    int lg_n = 0;
    int ex_n = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        lg_ack <= lg_valid && !lg_ack;
        if (lg_valid && !lg_ack) begin
            lg_rdata <= lg_mem[lg_port];
            if (lg_write) lg_mem[lg_port] <= lg_wdata;
        end
        if (lg_valid && lg_ack && lg_n < 16) begin
            lg_log_port[lg_n] <= lg_port;
            lg_log_dat[lg_n]  <= lg_wdata;
            lg_n <= lg_n + 1;
        end
        ex_ack <= ex_valid && !ex_ack;
        if (ex_valid && !ex_ack) begin
            if (ex_sel_index) begin
                ex_ireg <= ex_wdata[3:0];
            end else begin
                ex_rdata <= (ex_ireg < 4'd11) ? ex_mem[ex_ireg] : 16'h0;
                if (ex_write && ex_ireg < 4'd11) ex_mem[ex_ireg] <= ex_wdata;
            end
        end
        if (ex_valid && ex_ack && ex_n < 16) begin
            ex_log_sel[ex_n] <= ex_sel_index;
            ex_log_dat[ex_n] <= ex_wdata;
            ex_n <= ex_n + 1;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [31:0] got_data;
    int          got_ready;
    int          ready_width;

    task automatic access(input logic wr, input logic [2:0] sz, input logic [11:0] a,
                          input logic [31:0] wd, input int limit);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        got_ready = 0; got_data = '0; ready_width = 0;
        for (int i = 0; i < limit && got_ready == 0; i++) begin
            if (rsp_ready) begin
                got_ready = 1;
                got_data = rsp_rdata;
            end else begin
                @(negedge clk);
            end
        end
        if (got_ready != 0) begin
            while (rsp_ready) begin
                ready_width++;
                @(negedge clk);
            end
        end
    endtask

    // {write, size, addr, wdata, expected read data}
    localparam logic [79:0] VEC [NVEC] = '{
        {1'b0, 3'd1, 12'h403, 32'h0,        32'h000000A3},  // R2
        {1'b0, 3'd2, 12'h404, 32'h0,        32'h0000A5A4},  // R4
        {1'b1, 3'd2, 12'h410, 32'h00005A3C, 32'h0},         // R3
        {1'b0, 3'd2, 12'h410, 32'h0,        32'h00005A3C},  // R3
        {1'b0, 3'd4, 12'h41C, 32'h0,        32'hBFBEBDBC},  // R8
        {1'b0, 3'd2, 12'h504, 32'h0,        32'h0000B202},  // R6
        {1'b1, 3'd2, 12'h506, 32'h00001234, 32'h0},         // R6
        {1'b0, 3'd2, 12'h507, 32'h0,        32'h00001234},  // R6
        {1'b0, 3'd1, 12'h509, 32'h0,        32'h000000B4},  // R7
        {1'b0, 3'd1, 12'h508, 32'h0,        32'h00000004},  // R7
        {1'b0, 3'd4, 12'h500, 32'h0,        32'hB101B000},  // R8
        {1'b0, 3'd4, 12'h514, 32'h0,        32'h0000BA0A},  // R9
        {1'b0, 3'd2, 12'h200, 32'h0,        32'h0},         // R9
        {1'b1, 3'd4, 12'h800, 32'hFFFFFFFF, 32'h0},         // R9
        {1'b0, 3'd2, 12'h41F, 32'h0,        32'h000000BF},  // R9
        {1'b1, 3'd1, 12'h50B, 32'h00000077, 32'h0},         // R7
        {1'b0, 3'd2, 12'h50A, 32'h0,        32'h00007700},  // R7
        {1'b1, 3'd4, 12'h418, 32'h44332211, 32'h0},         // R8
        {1'b0, 3'd4, 12'h418, 32'h0,        32'h44332211},  // R8
        {1'b0, 3'd4, 12'h516, 32'h0,        32'h0},         // R9
        {1'b0, 3'd3, 12'h400, 32'h0,        32'hA3A2A1A0},  // R8
        {1'b1, 3'd4, 12'h510, 32'hCAFEBEEF, 32'h0},         // R8
        {1'b0, 3'd2, 12'h512, 32'h0,        32'h0000CAFE}   // R8
    };
    localparam string VTAG [NVEC] = '{"R2","R4","R3","R3","R8","R6","R6","R6","R7","R7",
        "R8","R9","R9","R9","R9","R7","R7","R8","R8","R9","R8","R8","R8"};

    initial begin
        for (int i = 0; i < 32; i++) lg_mem[i] = 8'hA0 + 8'(i);
        for (int i = 0; i < 11; i++) ex_mem[i] = 16'hB000 + 16'(i) * 16'h0101;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset rsp_ready", 32'(rsp_ready), 32'h0);
        check("R10 reset lg_valid", 32'(lg_valid), 32'h0);
        check("R10 reset ex_valid", 32'(ex_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            access(VEC[v][79], VEC[v][78:76], VEC[v][75:64], VEC[v][63:32], 200);
            check({VTAG[v], " ready"}, 32'(got_ready), 32'h1);
            check({VTAG[v], " data"}, got_data, VEC[v][31:0]);
            check("R10 ready pulse width", 32'(ready_width), 32'h1);
        end

        // R3: order of byte cycles for a 2-byte legacy write
        lg_n = 0;
        access(1'b1, 3'd2, 12'h408, 32'h00006655, 200);
        check("R3 cycle count", 32'(lg_n), 32'd2);
        check("R3 first port", 32'(lg_log_port[0]), 32'h08);
        check("R3 first byte", 32'(lg_log_dat[0]), 32'h55);
        check("R3 second port", 32'(lg_log_port[1]), 32'h09);
        check("R3 second byte", 32'(lg_log_dat[1]), 32'h66);

        // R5: index cycle then data cycle
        ex_n = 0;
        access(1'b0, 3'd2, 12'h50E, 32'h0, 200);
        check("R5 cycle count", 32'(ex_n), 32'd2);
        check("R5 index cycle first", 32'(ex_log_sel[0]), 32'h1);
        check("R5 index value", 32'(ex_log_dat[0]), 32'd7);
        check("R5 data cycle second", 32'(ex_log_sel[1]), 32'h0);

        // R9: write outside both areas makes no downstream cycle
        lg_n = 0; ex_n = 0;
        access(1'b1, 3'd4, 12'h300, 32'h12345678, 200);
        check("R9 ready outside", 32'(got_ready), 32'h1);
        check("R9 no downstream", 32'(lg_n + ex_n), 32'd0);

        // R1: disabled window ignores request
        lg_n = 0; ex_n = 0;
        en = 1'b0;
        access(1'b0, 3'd2, 12'h404, 32'h0, 20);
        check("R1 no ready when disabled", 32'(got_ready), 32'h0);
        check("R1 no downstream when disabled", 32'(lg_n + ex_n), 32'd0);
        en = 1'b1;

        // R1: enable drops inside an accepted access
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 3'd4; req_addr = 12'h41C;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        en = 1'b0;
        got_ready = 0; got_data = '0; ready_width = 0;
        for (int i = 0; i < 200 && got_ready == 0; i++) begin
            if (rsp_ready) begin got_ready = 1; got_data = rsp_rdata; end
            else @(negedge clk);
        end
        while (rsp_ready) begin ready_width++; @(negedge clk); end
        check("R1 access completes after en falls", 32'(got_ready), 32'h1);
        check("R1 data after en falls", got_data, 32'hBFBEBDBC);
        check("R10 single pulse", 32'(ready_width), 32'h1);
        en = 1'b1;

        summary();
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule